// File: doc/BRIEF.md
# Serial Converter Port Responder

This block is a synthesizable stand-in for the digital side of a 14-bit serial sampling converter. It is meant as a loopback partner for host-side serial port logic in verification. The host drives a chip select, a frame sync and a serial clock. The responder runs on its own system clock. It brings all three host lines through synchronizers and finds their edges there.

When a cycle starts, the responder takes the value on its parallel sample input. It then shifts out the result held from the previous completed cycle, most significant bit first. After that it counts serial clock falling edges through the sampling window. When the window closes, it spends a fixed number of system clocks converting. The value latched at the start is then placed in the holding register that feeds the next cycle.

Two control styles are selected by a mode pin:
- **Select-only mode:** a falling chip select starts the cycle.
- **Frame-sync mode:** chip select is held low. A rising frame sync starts the cycle, and sampling begins when frame sync falls.

A start that arrives while a cycle is still in progress abandons that cycle and raises a one-clock error pulse.

Top module: `adc_resp_top`

## Requirements
- R1: While reset is held and after it is released with no activity on the host lines, sdo, sampling, converting and restart_err are all 0.
- R2: At a start event, sdo shows bit 13 of the holding register. This happens in the same cycle that the start is taken.
- R3: Bits change on serial clock rising edges. The first rising edge after a start leaves bit 13 on sdo. Rising edge k (k = 2 to 14) puts bit 14−k on sdo, so the LSB appears on the 14th edge. The 15th rising edge ends the frame, and sdo returns to 0.
- R4: In select-only mode (fs_mode = 0), sdo is 0 whenever the synchronized chip select is high, even in the middle of a frame. The falling-edge count is not affected.
- R5: In frame-sync mode (fs_mode = 1), a rising frame sync while chip select is low starts the cycle and presents the MSB. Sampling stays 0 until frame sync falls. In select-only mode, sampling begins at the start itself.
- R6: sampling is 1 from the sampling start until the WIN_FALLS-th (24th by default) serial clock falling edge. converting rises in the same cycle that sampling falls.
- R7: converting stays high for exactly CONV_CYCLES system clocks. Afterwards, the sample taken at that cycle's start becomes the holding register value.
- R8: The word shifted out in a cycle is the sample latched at the start of the previous completed cycle. The first cycle after reset shifts out all zeros.
- R9: A start that arrives while a cycle is armed, sampling or converting pulses restart_err for one clock. The abandoned cycle leaves the holding register unchanged, and the new cycle starts normally.
- R10: Each host line passes through SYNC_STAGES flip-flops plus one edge register. With the default of 2 stages, an output responds on the third system clock edge after the line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_mode | input | 1 | 0: select-only control, 1: frame-sync control with select held low |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| fs | input | 1 | Host frame sync, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sample_in | input | DATA_W | Parallel sample value, latched at each start |
| sdo | output | 1 | Serial data out, MSB first |
| sampling | output | 1 | High during the sampling window |
| converting | output | 1 | High during the conversion period |
| restart_err | output | 1 | One-clock pulse on a premature restart |

## Verification
Most internal faults in this block show up on sdo within one serial clock period.
- A wrong shift count or a misplaced frame end moves or repeats a bit within the 14 rising edges of a frame.
- A holding register that loads at the wrong time, or is updated by an abandoned cycle, shows up only one full cycle later. It appears as a wrong word shifted out.
- A mis-counted window or conversion length moves the edges of sampling and converting by whole serial clock periods or single system clocks. These are caught on the clock edge where they first differ.
- A mis-tracked busy state shows up on restart_err in the cycle of the next start.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARMED   = 2'd1,
        PH_SAMPLE  = 2'd2,
        PH_CONVERT = 2'd3
    } phase_e;

    localparam int LINE_CS   = 0;
    localparam int LINE_FS   = 1;
    localparam int LINE_SCLK = 2;
    localparam int LINES     = 3;

endpackage

// File: rtl/adc_resp_sync.sv
module adc_resp_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);

    logic [W-1:0] prv_d, prv_q;

    for (genvar gi = 0; gi < W; gi++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], line_i[gi]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[gi]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign lvl_o[gi] = chain_q[STAGES-1];
    end

    always_comb begin
        prv_d = lvl_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_q <= RST_VAL;
        end else begin
            prv_q <= prv_d;
        end
    end

    assign prv_o = prv_q;

endmodule

// File: rtl/adc_resp_shifter.sv
module adc_resp_shifter #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sclk_rise_i,
    input  logic              gate_i,
    input  logic [DATA_W-1:0] load_i,
    output logic              sdo_o
);

    localparam int RISE_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [RISE_W-1:0] rises;
        logic              frame;
        logic              sdo;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.sh    = load_i;
            st_d.rises = '0;
            st_d.frame = 1'b1;
        end else if (st_q.frame && sclk_rise_i) begin
            if (st_q.rises == RISE_W'(DATA_W)) begin
                st_d.frame = 1'b0;
            end else begin
                st_d.rises = st_q.rises + 1'b1;
                if (st_q.rises != '0) begin
                    st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
                end
            end
        end
        st_d.sdo = st_d.frame & st_d.sh[DATA_W-1] & gate_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o = st_q.sdo;

endmodule

// File: rtl/adc_resp_seq.sv
module adc_resp_seq
    import adc_resp_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int WIN_FALLS   = 24,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fs_mode_i,
    input  logic              fs_fall_i,
    input  logic              sclk_fall_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] held_o,
    output logic              sampling_o,
    output logic              converting_o,
    output logic              busy_o,
    output logic              err_o
);

    localparam int FALL_W = $clog2(WIN_FALLS + 1);
    localparam int CONV_W = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        phase_e            phase;
        logic [FALL_W-1:0] falls;
        logic [CONV_W-1:0] conv;
        logic [DATA_W-1:0] latch;
        logic [DATA_W-1:0] held;
        logic              err;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d     = sq_q;
        sq_d.err = 1'b0;
        if (start_i) begin
            sq_d.err   = (sq_q.phase != PH_IDLE);
            sq_d.latch = sample_i;
            sq_d.phase = fs_mode_i ? PH_ARMED : PH_SAMPLE;
            sq_d.falls = '0;
            sq_d.conv  = '0;
        end else begin
            unique case (sq_q.phase)
                PH_ARMED: begin
                    if (fs_fall_i) begin
                        sq_d.phase = PH_SAMPLE;
                        sq_d.falls = '0;
                    end
                end
                PH_SAMPLE: begin
                    if (sclk_fall_i) begin
                        if (sq_q.falls == FALL_W'(WIN_FALLS - 1)) begin
                            sq_d.phase = PH_CONVERT;
                            sq_d.conv  = '0;
                        end else begin
                            sq_d.falls = sq_q.falls + 1'b1;
                        end
                    end
                end
                PH_CONVERT: begin
                    if (sq_q.conv == CONV_W'(CONV_CYCLES - 1)) begin
                        sq_d.phase = PH_IDLE;
                        sq_d.held  = sq_q.latch;
                    end else begin
                        sq_d.conv = sq_q.conv + 1'b1;
                    end
                end
                default: begin
                    sq_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign held_o       = sq_q.held;
    assign sampling_o   = (sq_q.phase == PH_SAMPLE);
    assign converting_o = (sq_q.phase == PH_CONVERT);
    assign busy_o       = (sq_q.phase != PH_IDLE);
    assign err_o        = sq_q.err;

endmodule

// File: rtl/adc_resp_top.sv
module adc_resp_top
    import adc_resp_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int WIN_FALLS   = 24,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_mode,
    input  logic              cs_n,
    input  logic              fs,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sampling,
    output logic              converting,
    output logic              restart_err
);

    localparam logic [LINES-1:0] IDLE_LINES = LINES'(1) << LINE_CS;

    logic [LINES-1:0] lines, lvl, prv;
    logic             cs_lvl, cs_fall, fs_rise, fs_fall;
    logic             sclk_rise, sclk_fall, start_ev, gate, busy;
    logic [DATA_W-1:0] held;

    assign lines[LINE_CS]   = cs_n;
    assign lines[LINE_FS]   = fs;
    assign lines[LINE_SCLK] = sclk;

    adc_resp_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE_LINES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(lines),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    assign cs_lvl    = lvl[LINE_CS];
    assign cs_fall   = ~lvl[LINE_CS] & prv[LINE_CS];
    assign fs_rise   = lvl[LINE_FS] & ~prv[LINE_FS];
    assign fs_fall   = ~lvl[LINE_FS] & prv[LINE_FS];
    assign sclk_rise = lvl[LINE_SCLK] & ~prv[LINE_SCLK];
    assign sclk_fall = ~lvl[LINE_SCLK] & prv[LINE_SCLK];

    assign start_ev = fs_mode ? (fs_rise & ~cs_lvl) : cs_fall;
    assign gate     = fs_mode | ~cs_lvl;

    adc_resp_seq #(
        .DATA_W     (DATA_W),
        .WIN_FALLS  (WIN_FALLS),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_ev),
        .fs_mode_i   (fs_mode),
        .fs_fall_i   (fs_fall),
        .sclk_fall_i (sclk_fall),
        .sample_i    (sample_in),
        .held_o      (held),
        .sampling_o  (sampling),
        .converting_o(converting),
        .busy_o      (busy),
        .err_o       (restart_err)
    );

    adc_resp_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_ev),
        .sclk_rise_i(sclk_rise),
        .gate_i     (gate),
        .load_i     (held),
        .sdo_o      (sdo)
    );

endmodule

// File: rtl/adc_resp_chk.sv
module adc_resp_chk #(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_mode,
    input logic              sdo,
    input logic              sampling,
    input logic              converting,
    input logic              restart_err,
    input logic              start_ev,
    input logic              sclk_rise,
    input logic              cs_lvl,
    input logic              busy,
    input logic [DATA_W-1:0] held
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 2);

    logic [CNT_W-1:0] conv_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_len_q <= '0;
        end else if (converting) begin
            if (conv_len_q != {CNT_W{1'b1}}) conv_len_q <= conv_len_q + 1'b1;
        end else begin
            conv_len_q <= '0;
        end
    end

    AST_MSB_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_ev) |-> (sdo == $past(held[DATA_W-1]))); // R2

    AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_ev) && !$past(sclk_rise) && $past(fs_mode) && $past(fs_mode, 2))
        |-> $stable(sdo)); // R3

    AST_SDO_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!fs_mode && cs_lvl) |-> !sdo); // R4

    AST_CONV_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> $past(sampling)); // R6

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(converting) && !restart_err) |-> (conv_len_q == CNT_W'(CONV_CYCLES))); // R7

    AST_ERR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        restart_err |-> $past(busy)); // R9

    AST_HOLD_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> ($past(converting) && !restart_err)); // R9

endmodule

bind adc_resp_top adc_resp_chk #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_mode    (fs_mode),
    .sdo        (sdo),
    .sampling   (sampling),
    .converting (converting),
    .restart_err(restart_err),
    .start_ev   (start_ev),
    .sclk_rise  (sclk_rise),
    .cs_lvl     (cs_lvl),
    .busy       (busy),
    .held       (held)
);

// File: tb/tb_adc_resp_top.sv
`timescale 1ns/1ps
module tb_adc_resp_top;

    localparam int DW   = 14;
    localparam int WIN  = 24;
    localparam int CONV = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs_mode = 1'b0;
    logic cs_n = 1'b1;
    logic fs = 1'b0;
    logic sclk = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic sdo, sampling, converting, restart_err;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    adc_resp_top #(.DATA_W(DW), .WIN_FALLS(WIN), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .fs_mode(fs_mode), .cs_n(cs_n), .fs(fs), .sclk(sclk),
        .sample_in(sample_in), .sdo(sdo), .sampling(sampling), .converting(converting),
        .restart_err(restart_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: line delay queues, integer counters and a bit index
    bit q_cs[$], q_fs[$], q_sk[$];
    bit o_cs, o_fs, o_sk;
    int m_phase;       // 0 idle, 1 armed, 2 sample, 3 convert
    int m_falls, m_conv, m_rises;
    bit m_frame, m_err;
    logic [DW-1:0] m_word, m_latch, m_held;
    bit exp_sdo;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_cs = '{1, 1}; q_fs = '{0, 0}; q_sk = '{0, 0};
            o_cs = 1; o_fs = 0; o_sk = 0;
            m_phase = 0; m_falls = 0; m_conv = 0; m_rises = 0;
            m_frame = 0; m_err = 0; m_word = '0; m_latch = '0; m_held = '0; exp_sdo = 0;
        end else begin
            bit n_cs, n_fs, n_sk, start, f_fall, k_rise, k_fall;
            int idx;
            n_cs = q_cs[0]; n_fs = q_fs[0]; n_sk = q_sk[0];
            f_fall = !n_fs && o_fs;
            k_rise = n_sk && !o_sk;
            k_fall = !n_sk && o_sk;
            start  = fs_mode ? (n_fs && !o_fs && !n_cs) : (!n_cs && o_cs);
            m_err = 0;
            if (start) begin
                m_err = (m_phase != 0);
                m_latch = sample_in; m_word = m_held;
                m_rises = 0; m_frame = 1;
                m_phase = fs_mode ? 1 : 2;
                m_falls = 0; m_conv = 0;
            end else begin
                if (m_phase == 1 && f_fall) begin
                    m_phase = 2; m_falls = 0;
                end else if (m_phase == 2 && k_fall) begin
                    m_falls++;
                    if (m_falls == WIN) begin m_phase = 3; m_conv = 0; end
                end else if (m_phase == 3) begin
                    m_conv++;
                    if (m_conv == CONV) begin m_phase = 0; m_held = m_latch; end
                end
                if (m_frame && k_rise) begin
                    if (m_rises == DW) m_frame = 0;
                    else m_rises++;
                end
            end
            idx = (m_rises <= 1) ? DW - 1 : DW - m_rises;
            exp_sdo = m_frame && (fs_mode || !n_cs) && m_word[idx];
            o_cs = n_cs; o_fs = n_fs; o_sk = n_sk;
            void'(q_cs.pop_front()); void'(q_fs.pop_front()); void'(q_sk.pop_front());
            q_cs.push_back(cs_n); q_fs.push_back(fs); q_sk.push_back(sclk);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 sdo vs model", sdo, exp_sdo);
            check("R6 sampling vs model", sampling, m_phase == 2);
            check("R7 converting vs model", converting, m_phase == 3);
            check("R9 restart_err vs model", restart_err, m_err);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sclk = 1'b1; wait_n(4);
        sclk = 1'b0; wait_n(4);
    endtask

    task automatic grab_word(output logic [DW-1:0] w);
        for (int k = 1; k <= DW; k++) begin
            sclk = 1'b1; wait_n(4);
            w[DW-k] = sdo;
            sclk = 1'b0; wait_n(4);
        end
    endtask

    task automatic finish_window(input int already);
        for (int k = already; k < WIN; k++) pulse();
    endtask

    localparam logic [DW-1:0] S_A = 14'h2C35;
    localparam logic [DW-1:0] S_B = 14'h3A5C;
    localparam logic [DW-1:0] S_C = 14'h2001;
    localparam logic [DW-1:0] S_D = 14'h1B6E;
    localparam logic [DW-1:0] S_E = 14'h0F0F;
    localparam logic [DW-1:0] S_F = 14'h35A3;
    localparam logic [DW-1:0] S_G = 14'h2D4B;

    initial begin
        logic [DW-1:0] w;
        wait_n(3);
        check("R1 sdo in reset", sdo, 0);
        check("R1 sampling in reset", sampling, 0);
        rst_n = 1'b1;
        wait_n(5);
        check("R1 sdo idle", sdo, 0);
        check("R1 converting idle", converting, 0);
        check("R1 restart_err idle", restart_err, 0);

        // cycle 1: select-only, reset holding value
        sample_in = S_A;
        cs_n = 1'b0;
        wait_n(2);
        check("R10 sampling before latency", sampling, 0);
        wait_n(1);
        check("R10 sampling after latency", sampling, 1);
        grab_word(w);
        check("R8 first word is zero", int'(w), 0);
        finish_window(DW);
        cs_n = 1'b1;
        wait_n(CONV + 10);
        check("R7 idle after conversion", converting, 0);

        // cycle 2: word must be A
        sample_in = S_B;
        cs_n = 1'b0;
        wait_n(2);
        check("R2 sdo before start", sdo, 0);
        wait_n(1);
        check("R2 MSB at start", sdo, S_A[DW-1]);
        grab_word(w);
        check("R8 word equals prior sample A", int'(w), int'(S_A));
        finish_window(DW);
        cs_n = 1'b1;
        wait_n(CONV + 10);

        // cycle 3: chip select released mid frame
        sample_in = S_C;
        cs_n = 1'b0;
        wait_n(4);
        pulse(); pulse(); pulse();
        check("R3 bit 11 of B before release", sdo, S_B[11]);
        cs_n = 1'b1;
        wait_n(6);
        check("R4 sdo low with select high", sdo, 0);
        finish_window(3);
        wait_n(CONV + 10);

        // cycle 4: frame-sync mode
        fs_mode = 1'b1;
        wait_n(5);
        cs_n = 1'b0;
        wait_n(5);
        sample_in = S_D;
        fs = 1'b1;
        wait_n(3);
        check("R5 MSB after frame sync rise", sdo, S_C[DW-1]);
        wait_n(3);
        check("R5 no sampling while armed", sampling, 0);
        fs = 1'b0;
        wait_n(3);
        check("R5 sampling after frame sync fall", sampling, 1);
        grab_word(w);
        check("R8 word equals sample C", int'(w), int'(S_C));
        finish_window(DW);
        wait_n(CONV + 10);

        // cycle 5: restart during conversion
        sample_in = S_E;
        fs = 1'b1; wait_n(5); fs = 1'b0; wait_n(5);
        finish_window(0);
        wait_n(10);
        check("R6 converting after window", converting, 1);
        sample_in = S_F;
        fs = 1'b1;
        wait_n(3);
        check("R9 error pulse on early restart", restart_err, 1);
        wait_n(1);
        check("R9 error lasts one clock", restart_err, 0);
        wait_n(2);
        fs = 1'b0; wait_n(5);
        grab_word(w);
        check("R9 holding value unchanged after abort", int'(w), int'(S_D));
        finish_window(DW);
        wait_n(CONV + 10);

        // cycle 6: select-only restart during sampling
        cs_n = 1'b1;
        wait_n(5);
        fs_mode = 1'b0;
        wait_n(5);
        sample_in = S_G;
        cs_n = 1'b0;
        wait_n(4);
        pulse(); pulse(); pulse(); pulse(); pulse();
        cs_n = 1'b1; wait_n(4);
        cs_n = 1'b0;
        wait_n(3);
        check("R9 error on restart in window", restart_err, 1);
        grab_word(w);
        check("R8 word equals sample F", int'(w), int'(S_F));
        finish_window(DW);
        cs_n = 1'b1;
        wait_n(CONV + 10);

        // cycle 7: completion of restarted cycle delivered
        sample_in = S_A;
        cs_n = 1'b0;
        wait_n(4);
        grab_word(w);
        check("R7 word equals sample G", int'(w), int'(S_G));
        finish_window(DW);
        cs_n = 1'b1;
        wait_n(CONV + 10);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule